// File: doc/BRIEF.md
# I2C bus time-out detector

This block watches an I2C bus for two kinds of stall and raises a sticky flag for each. A programmable pre-divider turns the system clock into a slower function-clock tick, and both time-out counters advance only on that tick. The event time-out counts the time between bus events (Start, Stop or any SCL edge) while a transaction is in progress. The SCL time-out counts how long SCL stays low, whether or not a transaction is open.

Both detectors share one 12-bit interval value. Its unit is 16 function ticks, because the low four bits of the full count are fixed at ones. A flag, once set, stays set until a one is written to its clear strobe. Dropping the enable returns the whole block to its reset state. The SCL and SDA inputs must already be synchronized to the system clock.

A bus monitor state machine has two states, BUS_IDLE and BUS_BUSY. It starts in BUS_IDLE, and BUS_IDLE is forced while the enable is low. The transition BUS_IDLE to BUS_BUSY is taken on a Start. The transition BUS_BUSY to BUS_IDLE is taken on a Stop. A Start is SDA falling while SCL is high in two consecutive samples. A Stop is SDA rising while SCL is high in two consecutive samples.

Top module: `i2c_bus_timeout`

## Requirements
- R1: With divider value N, `func_tick` is high for one system clock out of every N+1 while enabled. N=0 gives a tick on every clock.
- R2: With interval value T, a time-out fires after (T+1)*16 function ticks of uninterrupted condition. That is 16 ticks at T=0 and 65,536 ticks at T=0xFFF.
- R3: While the bus is busy, the event counter restarts on every Start, Stop or SCL edge. `evt_timeout` sets only after a gap with no event that lasts the full interval.
- R4: While the bus monitor is in BUS_IDLE (after reset, or after a Stop), `evt_timeout` never sets, however long the bus stays quiet.
- R5: `scl_timeout` sets when SCL has stayed low for the full interval. Any clock with SCL high restarts that count, and no time-out is raised while SCL is high.
- R6: Each flag stays at 1 until its clear strobe is high at a clock edge. If a new time-out and the clear fall in the same clock, the flag stays set.
- R7: While `tmo_en` is 0, both flags read 0, no tick is produced, and both counters and the bus monitor are held at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_en | input | 1 | Time-out enable; 0 holds all logic in reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| div_val | input | 16 | Pre-divider value N, tick period N+1 clocks |
| tmo_val | input | 12 | Interval value T, time-out after (T+1)*16 ticks |
| evt_clr | input | 1 | Write-one clear of the event time-out flag |
| scl_clr | input | 1 | Write-one clear of the SCL time-out flag |
| func_tick | output | 1 | Function-clock tick from the pre-divider |
| evt_timeout | output | 1 | Sticky event time-out flag |
| scl_timeout | output | 1 | Sticky SCL-low time-out flag |

## Verification
A clear strobe and a fresh time-out can land on the same clock edge. In that case the set must win, so the flag must not be lost.

The bench provokes this case by counting function ticks from the exact clock where SCL first samples low. It raises `scl_clr` only for the clock in which the 16th tick completes. It then expects `scl_timeout` to read 1 afterwards.

The bench also runs a behavioural reference model beside the design and compares all three outputs on every clock. This catches any off-by-one in the divider, the interval length or the restart rules.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

    // Bus monitor states
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    // Low interval bits fixed at ones: 16-tick resolution
    localparam int SUB_BITS = 4;

endpackage

// File: rtl/i2c_tmo_prediv.sv
module i2c_tmo_prediv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: a tick is never followed by another unless the divider is zero
    p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (tick && div_val != '0) |=> (!tick || div_val == '0));

endmodule

// File: rtl/i2c_tmo_busmon.sv
module i2c_tmo_busmon
    import i2c_tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl,
    input  logic sda,
    output logic bus_event,
    output logic bus_busy
);

    bus_state_e state_q, state_d;
    logic       scl_q, sda_q;
    logic       start_c, stop_c, edge_c;

    assign start_c = scl_q && scl && sda_q && !sda;
    assign stop_c  = scl_q && scl && !sda_q && sda;
    assign edge_c  = scl_q != scl;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (start_c) state_d = BUS_BUSY;
            BUS_BUSY: if (stop_c)  state_d = BUS_IDLE;
        endcase
    end

    // State and line history registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
        end else if (!en) begin
            state_q <= BUS_IDLE;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            scl_q   <= scl;
            sda_q   <= sda;
        end
    end

    // Outputs
    always_comb begin
        bus_event = en && (start_c || stop_c || edge_c);
        bus_busy  = (state_q == BUS_BUSY);
    end

endmodule

// File: rtl/i2c_tmo_timer.sv
module i2c_tmo_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last_c;

    assign last_c = (cnt_q == limit - 1'b1);
    assign hit    = en && !restart && tick && !done_q && last_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!en || restart) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_c) begin
                done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_timeout.sv
module i2c_bus_timeout
    import i2c_tmo_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TO_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_en,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [DIV_W-1:0] div_val,
    input  logic [TO_W-1:0]  tmo_val,
    input  logic             evt_clr,
    input  logic             scl_clr,
    output logic             func_tick,
    output logic             evt_timeout,
    output logic             scl_timeout
);

    localparam int CNT_W = TO_W + SUB_BITS + 1;

    logic [CNT_W-1:0] limit;
    logic             bus_event, bus_busy;
    logic             evt_hit, scl_hit;
    logic             evt_flag_q, scl_flag_q;

    // (T+1)*16 ticks: {T, 4'hF} + 1
    assign limit = {1'b0, tmo_val, {SUB_BITS{1'b1}}} + 1'b1;

    i2c_tmo_prediv #(.DIV_W(DIV_W)) u_prediv (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tmo_en),
        .div_val (div_val),
        .tick    (func_tick)
    );

    i2c_tmo_busmon u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tmo_en),
        .scl       (scl_in),
        .sda       (sda_in),
        .bus_event (bus_event),
        .bus_busy  (bus_busy)
    );

    i2c_tmo_timer #(.CNT_W(CNT_W)) u_evt_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tmo_en),
        .restart (bus_event || !bus_busy),
        .tick    (func_tick),
        .limit   (limit),
        .hit     (evt_hit)
    );

    i2c_tmo_timer #(.CNT_W(CNT_W)) u_scl_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tmo_en),
        .restart (scl_in),
        .tick    (func_tick),
        .limit   (limit),
        .hit     (scl_hit)
    );

    // Sticky flags: a new hit outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_flag_q <= 1'b0;
            scl_flag_q <= 1'b0;
        end else if (!tmo_en) begin
            evt_flag_q <= 1'b0;
            scl_flag_q <= 1'b0;
        end else begin
            evt_flag_q <= (evt_flag_q && !evt_clr) || evt_hit;
            scl_flag_q <= (scl_flag_q && !scl_clr) || scl_hit;
        end
    end

    assign evt_timeout = evt_flag_q;
    assign scl_timeout = scl_flag_q;

    // R4: an idle bus never produces an event time-out
    p_evt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !evt_hit);

    // R5: no SCL time-out while SCL is high
    p_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_in |-> !scl_hit);

    // R6: a set flag without a clear stays set
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n || !tmo_en)
        (scl_timeout && !scl_clr) |=> scl_timeout);

    // R7: disabled block shows no flags
    p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_en |=> (!evt_timeout && !scl_timeout));

endmodule

// File: tb/i2c_bus_timeout_tb.sv
module i2c_bus_timeout_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmo_en = 1'b0;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic [15:0] div_val = '0;
    logic [11:0] tmo_val = '0;
    logic        evt_clr = 1'b0;
    logic        scl_clr = 1'b0;
    logic        func_tick, evt_timeout, scl_timeout;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    i2c_bus_timeout u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en),
        .scl_in(scl_in), .sda_in(sda_in),
        .div_val(div_val), .tmo_val(tmo_val),
        .evt_clr(evt_clr), .scl_clr(scl_clr),
        .func_tick(func_tick), .evt_timeout(evt_timeout), .scl_timeout(scl_timeout)
    );

    // Behavioural reference model
    int m_div, m_ecnt, m_scnt;
    bit m_edone, m_sdone, m_busy, m_pscl, m_psda, m_fe, m_fs;

    task automatic model_reset();
        m_div = 0; m_ecnt = 0; m_scnt = 0;
        m_edone = 0; m_sdone = 0; m_busy = 0;
        m_pscl = 1; m_psda = 1; m_fe = 0; m_fs = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n || !tmo_en) begin
            model_reset();
        end else begin
            int lim;
            bit tk, st, sp, ev, ehit, shit;
            lim  = (int'(tmo_val) + 1) * 16;
            tk   = (m_div == int'(div_val));
            st   = m_pscl && scl_in && m_psda && !sda_in;
            sp   = m_pscl && scl_in && !m_psda && sda_in;
            ev   = st || sp || (m_pscl != scl_in);
            ehit = !(ev || !m_busy) && tk && !m_edone && (m_ecnt == lim - 1);
            shit = !scl_in && tk && !m_sdone && (m_scnt == lim - 1);
            if (ev || !m_busy) begin
                m_ecnt = 0; m_edone = 0;
            end else if (tk && !m_edone) begin
                if (m_ecnt == lim - 1) m_edone = 1;
                m_ecnt++;
            end
            if (scl_in) begin
                m_scnt = 0; m_sdone = 0;
            end else if (tk && !m_sdone) begin
                if (m_scnt == lim - 1) m_sdone = 1;
                m_scnt++;
            end
            m_fe = (m_fe && !evt_clr) || ehit;
            m_fs = (m_fs && !scl_clr) || shit;
            if (st) m_busy = 1;
            else if (sp) m_busy = 0;
            m_div  = tk ? 0 : m_div + 1;
            m_pscl = scl_in;
            m_psda = sda_in;
        end
    end

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                check(func_tick, tmo_en && (m_div == int'(div_val)), "R1 per-cycle tick");
                check(evt_timeout, m_fe, "R3 per-cycle event flag");
                check(scl_timeout, m_fs, "R5 per-cycle scl flag");
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input bit c, input bit d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
    endtask

    // Watchdog
    initial begin
        #(8 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        clks(3);
        check(evt_timeout, 1'b0, "R7 reset event flag");
        check(scl_timeout, 1'b0, "R7 reset scl flag");
        check(func_tick, 1'b0, "R7 reset tick");
        rst_n = 1'b1;
        clks(2);

        // R1: tick every clock, then every fourth clock
        tmo_en = 1'b1;
        clks(2);
        check(func_tick, 1'b1, "R1 undivided tick");
        div_val = 16'd3;
        clks(4);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #2;
            if (func_tick) n++;
        end
        check(n == 10, 1'b1, "R1 divide-by-4 count");
        div_val = 16'd0;

        // R5 / R4: SCL held low on an idle bus
        bus(0, 1);
        clks(10);
        check(scl_timeout, 1'b0, "R5 before interval");
        clks(12);
        check(scl_timeout, 1'b1, "R5 after interval");
        check(evt_timeout, 1'b0, "R4 idle bus no event flag");
        bus(1, 1);
        clks(20);
        check(scl_timeout, 1'b1, "R6 flag sticky");
        scl_clr = 1'b1; clks(1); scl_clr = 1'b0; clks(1);
        check(scl_timeout, 1'b0, "R6 cleared");

        // R3: Start, then fast SCL toggling keeps event timer restarting
        bus(1, 0);
        for (int i = 0; i < 25; i++) begin
            bus(0, 0); clks(7);
            bus(1, 0); clks(7);
        end
        check(evt_timeout, 1'b0, "R3 active toggling");
        check(scl_timeout, 1'b0, "R5 short low phases");
        clks(25);
        check(evt_timeout, 1'b1, "R3 stalled busy bus");
        check(scl_timeout, 1'b0, "R5 SCL high no flag");
        evt_clr = 1'b1; clks(1); evt_clr = 1'b0; clks(1);
        check(evt_timeout, 1'b0, "R6 event cleared");

        // R6: clear in the same cycle as a new SCL time-out
        @(negedge clk); scl_in = 1'b0;
        clks(15);
        scl_clr = 1'b1;
        clks(1);
        scl_clr = 1'b0;
        check(scl_timeout, 1'b1, "R6 set wins over clear");
        scl_clr = 1'b1; clks(1); scl_clr = 1'b0;

        // Stop, then a long quiet idle bus
        bus(1, 0);
        bus(1, 1);
        clks(1);
        evt_clr = 1'b1; clks(1); evt_clr = 1'b0;
        clks(200);
        check(evt_timeout, 1'b0, "R4 idle after stop");

        // R2: div 3, T=1 -> 128 clocks
        div_val = 16'd3;
        tmo_val = 12'd1;
        bus(0, 1);
        clks(100);
        check(scl_timeout, 1'b0, "R2 before 32 ticks");
        clks(60);
        check(scl_timeout, 1'b1, "R2 after 32 ticks");

        // R7: disable clears and holds
        tmo_en = 1'b0;
        clks(2);
        check(scl_timeout, 1'b0, "R7 disabled clears flag");
        clks(300);
        check(scl_timeout, 1'b0, "R7 disabled stays clear");
        check(func_tick, 1'b0, "R7 no tick when disabled");

        // R2: maximum interval, undivided: 65536 clocks
        div_val = 16'd0;
        tmo_val = 12'hFFF;
        tmo_en  = 1'b1;
        clks(65000);
        check(scl_timeout, 1'b0, "R2 max interval not yet");
        clks(600);
        check(scl_timeout, 1'b1, "R2 max interval reached");
        bus(1, 1);
        clks(5);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule